// File: doc/BRIEF.md
# Single-clock FIFO with per-request handshake

This block is a first-in first-out buffer for one clock domain. Words written on one side come out on the other side in the order they went in. Both sides may make a request in the same cycle. The write pointer and the read pointer are plain binary counters. Each pointer carries one extra wrap bit, so the logic can tell a full buffer from an empty one. Full, empty, almost-full and almost-empty flags and an exact word count are derived from the two pointers. They change on the same edge that moves the pointers.

The block answers every request one cycle after it is made. An accepted write raises `wr_ack` and a write turned away raises `wr_rej`. An accepted read raises `rd_ack`, and the word it fetched is on `rd_data` at the same time. A read turned away raises `rd_rej`. Each side has its own synchronous clear. The write clear pulls the write pointer back onto the read pointer. The read clear pushes the read pointer forward onto the write pointer. Either clear leaves the buffer empty.

Top module: `sync_fifo_hs`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `empty` is 1, `count` is 0, and `full`, `almost_full`, `almost_empty`, `wr_ack`, `wr_rej`, `rd_ack` and `rd_rej` are all 0.
- R2: `full` is 1 exactly when `count` equals DEPTH (2**AW). `empty` is 1 exactly when `count` is 0.
- R3: A write made while `full` is 1 and no clear is active is dropped. `wr_rej` is 1 on the next cycle, `wr_ack` is 0, and the stored contents do not change.
- R4: A read made while `empty` is 1 and no clear is active is dropped. `rd_rej` is 1 on the next cycle, `rd_ack` is 0, and the count does not change.
- R5: A write made while `full` is 0 and no clear is active is stored. `wr_ack` is 1 on the next cycle and `wr_rej` is 0.
- R6: A read made while `empty` is 0 and no clear is active gives `rd_ack` = 1 on the next cycle. On that cycle `rd_data` holds the oldest stored word, so words come out in the order they were written.
- R7: `almost_full` is 1 exactly when `count` equals DEPTH-1. `almost_empty` is 1 exactly when `count` equals 1.
- R8: On each cycle with no clear, `count` goes up by one for an accepted write and down by one for an accepted read. It stays the same when both are accepted, and when neither is.
- R9: When `full` is 1 and both sides make a request, the read is accepted and the write is rejected. The count drops by one.
- R10: When `empty` is 1 and both sides make a request, the write is accepted and the read is rejected. The count rises to one.
- R11: In a cycle where `wr_clr` or `rd_clr` is 1, no request is accepted or rejected. On the next cycle `count` is 0 and `empty` is 1. All four handshake outputs are 0. The next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_clr | input | 1 | Synchronous write-side clear, active high |
| rd_clr | input | 1 | Synchronous read-side clear, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Word fetched by the last accepted read |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| almost_full | output | 1 | Buffer holds DEPTH-1 words |
| almost_empty | output | 1 | Buffer holds one word |
| count | output | AW+1 | Exact number of stored words |
| wr_ack | output | 1 | Write of the previous cycle was stored |
| wr_rej | output | 1 | Write of the previous cycle was refused because the buffer was full |
| rd_ack | output | 1 | Read of the previous cycle succeeded; `rd_data` is valid |
| rd_rej | output | 1 | Read of the previous cycle was refused because the buffer was empty |

## Verification
The hardest case to reach from the ports is a request made in the same cycle as a boundary condition. Examples are both sides asking while the buffer is exactly full or exactly empty, and a clear that arrives while a pointer has wrapped. The stimulus gets there by clearing and then refilling to every fill level from 0 to DEPTH. At each level it applies each of the four request pairs. It then runs a long stretch of random requests with occasional clears on either side, so the pointers wrap many times before a clear hits them. The expected flags, count and data come from a queue model kept in the bench.

// File: rtl/sync_fifo_hs.sv
module sync_fifo_hs #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_clr,
  input  logic          rd_clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty,
  output logic [AW:0]   count,
  output logic          wr_ack,
  output logic          wr_rej,
  output logic          rd_ack,
  output logic          rd_rej
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CNT_AF = (AW+1)'(DEPTH - 1);
  localparam logic [AW:0] CNT_AE = (AW+1)'(1);

  logic [AW:0]   wptr, rptr;
  logic [DW-1:0] mem [DEPTH];
  logic          clr, wr_go, rd_go;

  assign count        = wptr - rptr;
  assign empty        = (wptr == rptr);
  assign full         = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign almost_full  = (count == CNT_AF);
  assign almost_empty = (count == CNT_AE);

  assign clr   = wr_clr | rd_clr;
  assign wr_go = wr_en & ~full  & ~clr;
  assign rd_go = rd_en & ~empty & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (wr_clr && rd_clr) begin
      wptr <= '0;
      rptr <= '0;
    end else if (wr_clr) begin
      wptr <= rptr;
    end else if (rd_clr) begin
      rptr <= wptr;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (rd_go) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_go) begin
      rd_data <= mem[rptr[AW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ack <= 1'b0;
      wr_rej <= 1'b0;
      rd_ack <= 1'b0;
      rd_rej <= 1'b0;
    end else begin
      wr_ack <= wr_go;
      wr_rej <= wr_en & full & ~clr;
      rd_ack <= rd_go;
      rd_rej <= rd_en & empty & ~clr;
    end
  end
endmodule

// File: rtl/sync_fifo_hs_chk.sv
module sync_fifo_hs_chk #(
  parameter int AW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_clr,
  input logic        rd_clr,
  input logic        wr_en,
  input logic        rd_en,
  input logic        full,
  input logic        empty,
  input logic        almost_full,
  input logic        almost_empty,
  input logic [AW:0] count,
  input logic        wr_ack,
  input logic        wr_rej,
  input logic        rd_ack,
  input logic        rd_rej
);
  logic quiet;
  assign quiet = !wr_clr && !rd_clr;

  a_r2_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && wr_en && full && !rd_en) |=> (wr_rej && !wr_ack && count == $past(count)));

  a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && rd_en && empty && !wr_en) |=> (rd_rej && !rd_ack && count == $past(count)));

  a_r5_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && wr_en && !full) |=> (wr_ack && !wr_rej));

  a_r6_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && rd_en && !empty) |=> (rd_ack && !rd_rej));

  a_r7_almost_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(almost_full && full) && !(almost_empty && empty));

  a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && wr_en && !full && !(rd_en && !empty)) |=> (count == $past(count) + 1'b1));

  a_r9_full_both: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && full && wr_en && rd_en) |=> (rd_ack && wr_rej && !full));

  a_r10_empty_both: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && empty && wr_en && rd_en) |=> (wr_ack && rd_rej && almost_empty));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr || rd_clr) |=> (empty && count == '0 && !wr_ack && !wr_rej && !rd_ack && !rd_rej));
endmodule

bind sync_fifo_hs sync_fifo_hs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_clr(wr_clr), .rd_clr(rd_clr),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
  .almost_full(almost_full), .almost_empty(almost_empty), .count(count),
  .wr_ack(wr_ack), .wr_rej(wr_rej), .rd_ack(rd_ack), .rd_rej(rd_rej)
);

// File: tb/sync_fifo_hs_bench.sv
`timescale 1ns/1ps
module sync_fifo_hs_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_clr = 1'b0, rd_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full, empty, almost_full, almost_empty;
  logic [AW:0]   count;
  logic          wr_ack, wr_rej, rd_ack, rd_rej;

  int checks = 0;
  int errors = 0;
  int q[$];
  logic [DW-1:0] next_word = 8'h01;

  always #2 clk = ~clk;

  sync_fifo_hs #(.DW(DW), .AW(AW)) u_sync_fifo_hs (
    .clk(clk), .rst_n(rst_n), .wr_clr(wr_clr), .rd_clr(rd_clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty), .count(count),
    .wr_ack(wr_ack), .wr_rej(wr_rej), .rd_ack(rd_ack), .rd_rej(rd_rej)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic status_chk(input string tag);
    int n = q.size();
    chk({tag, " R8 count"}, int'(count), n);
    chk({tag, " R2 full"}, int'(full), int'(n == DEPTH));
    chk({tag, " R2 empty"}, int'(empty), int'(n == 0));
    chk({tag, " R7 almost_full"}, int'(almost_full), int'(n == DEPTH-1));
    chk({tag, " R7 almost_empty"}, int'(almost_empty), int'(n == 1));
  endtask

  task automatic step(input logic we, input logic re, input logic wc, input logic rc, input string tag);
    bit was_full  = (q.size() == DEPTH);
    bit was_empty = (q.size() == 0);
    bit clr = wc | rc;
    bit wa = we && !was_full && !clr;
    bit ra = re && !was_empty && !clr;
    int exp_rd = 0;
    wr_en = we; rd_en = re; wr_clr = wc; rd_clr = rc; wr_data = next_word;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; wr_clr = 1'b0; rd_clr = 1'b0;
    if (clr) q.delete();
    else begin
      if (ra) exp_rd = q.pop_front();
      if (wa) begin q.push_back(int'(next_word)); next_word = next_word + 8'd1; end
    end
    chk({tag, " R5 wr_ack"}, int'(wr_ack), int'(wa));
    chk({tag, " R3 wr_rej"}, int'(wr_rej), int'(we && was_full && !clr));
    chk({tag, " R6 rd_ack"}, int'(rd_ack), int'(ra));
    chk({tag, " R4 rd_rej"}, int'(rd_rej), int'(re && was_empty && !clr));
    if (ra) chk({tag, " R6 rd_data"}, int'(rd_data), exp_rd);
    status_chk(tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset empty", int'(empty), 1);
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset handshake", int'({wr_ack, wr_rej, rd_ack, rd_rej, full}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset empty", int'(empty), 1);
    status_chk("R1");

    // fill past full, then drain past empty
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "fill");
    chk("R3 still full after overflow", int'(full), 1);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "drain");
    chk("R4 still empty after underflow", int'(empty), 1);

    // simultaneous requests at the boundaries
    step(1'b1, 1'b1, 1'b0, 1'b0, "R10");
    chk("R10 write taken, read refused", int'({wr_ack, rd_rej}), 3);
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "fill2");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R9");
    chk("R9 read taken, write refused", int'({rd_ack, wr_rej}), 3);

    // every fill level crossed with every request pair
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int pat = 0; pat < 4; pat++) begin
        step(1'b0, 1'b0, 1'b1, 1'b1, "R11 both clr");
        for (int k = 0; k < lvl; k++) step(1'b1, 1'b0, 1'b0, 1'b0, "sweep fill");
        step(pat[0], pat[1], 1'b0, 1'b0, "sweep");
      end
    end

    // clears in the middle of traffic, after wraps
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "pre");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R11 wr_clr");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R11 post");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R11 post read");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "pre");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R11 rd_clr");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R11 post");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R11 post read");

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic bias = (i / 500) % 2 == 1;
      logic we = ($urandom_range(0, 99) < (bias ? 70 : 40));
      logic re = ($urandom_range(0, 99) < (bias ? 40 : 70));
      step(we, re, r == 0, r == 1, "rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule